// File: doc/BRIEF.md
# Bidirectional Universal Bus Transceiver Register

This block joins two 18-bit buses, A and B, through a separate storage path for each direction. Each path has three controls: a latch enable, a capture clock and an output enable. With its latch enable high, a path is transparent and the far port follows the near port. With its latch enable low, the path shows a stored word. That word is loaded on the falling edge of the path clock, and it is also loaded at the moment the latch enable drops, so the last transparent value is kept. The two output enables have opposite polarity. The A-to-B enable is active high and the B-to-A enable is active low. A released port is high impedance, so other agents on the bus can drive it.

Each path runs a two-state mode machine. The states are PM_PASS, entered when the latch enable rises, and PM_HOLD, entered when the latch enable falls. Each port driver runs a two-state machine with the states DRV_OFF and DRV_ON, and its output enable moves it between them. The path input is always taken from the near side of its own port, so a port that the opposite path is driving can still be captured. The width is a parameter with a default of 18.

Top module: `ubt_xcvr`

## Requirements
- R1: While `rst_n` is low, both stored words are held at zero whatever the clocks do. After release, a path in hold mode shows zero.
- R2: With `ab_le` high and `ab_oe` high, `b_bus` equals `a_bus` in the same cycle, for every bit pattern.
- R3: With `ab_le` low and `ab_clk` held steady, either low or high, `b_bus` keeps the stored word while `a_bus` changes.
- R4: With `ab_le` low, a high-to-low transition of `ab_clk` loads the current `a_bus` into the A-to-B storage, and `b_bus` shows it.
- R5: A low-to-high transition of `ab_clk` or `ba_clk` never changes the stored word of its path.
- R6: When a latch enable falls, its path keeps the word that was present while it was transparent, until the next falling edge of its clock.
- R7: `ab_oe` is active high. When it is 1, `b_bus` is driven from the A-to-B path. When it is 0, `b_bus` is released, so an external driver sets its value with no conflict.
- R8: The B-to-A path uses `ba_le` and `ba_clk` to give the same transparent, hold and falling-edge capture modes from `b_bus` to `a_bus`.
- R9: `ba_oe_n` is active low. When it is 0, `a_bus` is driven from the B-to-A path. When it is 1, `a_bus` is released.
- R10: With both enables on and both paths in hold, each port shows its own path's stored word. A capture edge on one path then loads the word that the other path is driving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_bus | inout | WIDTH | Port A: input of the A-to-B path, driven by the B-to-A path |
| b_bus | inout | WIDTH | Port B: input of the B-to-A path, driven by the A-to-B path |
| rst_n | input | 1 | Asynchronous active-low reset; clears both stored words |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable; high means transparent |
| ab_clk | input | 1 | A-to-B capture clock; the falling edge loads storage |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable; high means transparent |
| ba_clk | input | 1 | B-to-A capture clock; the falling edge loads storage |

## Verification
Two functions can fall in the same cycle. One is a falling-edge capture on one path. The other is the opposite path driving that same port from its own storage. The bench provokes this by enabling both ports with both paths in hold, then dropping `ab_clk` and later `ba_clk`. It judges the result by whether the word captured on each side is the one the other path was driving. A second coincidence is a latch enable falling in the same step that the near-port data was just changed. The bench always settles the data before the control edge, and it expects the new data to be the word that is kept. A behavioural model recomputes both ports on every clock, and random steps cover mode and enable changes in any order.

// File: rtl/ubt_pkg.sv
`timescale 1ns/1ps
package ubt_pkg;
    // Mode of one storage path: transparent or showing the stored word.
    typedef enum logic {
        PM_HOLD = 1'b0,
        PM_PASS = 1'b1
    } path_mode_e;

    // State of one port driver.
    typedef enum logic {
        DRV_OFF = 1'b0,
        DRV_ON  = 1'b1
    } drv_state_e;
endpackage

// File: rtl/ubt_path.sv
`timescale 1ns/1ps
module ubt_path
    import ubt_pkg::*;
#(
    parameter int WIDTH = 18
)
(
    input  logic             rst_n,
    input  logic             cap_clk,
    input  logic             le,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] held
);
    path_mode_e       mode;
    logic [WIDTH-1:0] store_q;

    // Mode machine: a rising latch enable enters PM_PASS,
    // a falling latch enable enters PM_HOLD.
    always_comb begin
        unique case (le)
            1'b1:    mode = PM_PASS;
            default: mode = PM_HOLD;
        endcase
    end

    // Storage loads on a falling capture clock and on a falling latch enable.
    // A load while transparent is overwritten when the enable drops,
    // so only those loads are visible.
    always_ff @(negedge cap_clk or negedge le or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= din;
        end
    end

    // Output selection follows the mode machine.
    always_comb begin
        unique case (mode)
            PM_PASS: dout = din;
            PM_HOLD: dout = store_q;
            default: dout = store_q;
        endcase
    end

    assign held = store_q;
endmodule

// File: rtl/ubt_oe_ctl.sv
`timescale 1ns/1ps
module ubt_oe_ctl
    import ubt_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b0
)
(
    input  logic       oe_pin,
    output drv_state_e state
);
    logic oe_asserted;

    generate
        if (ACTIVE_LOW) begin : g_low
            assign oe_asserted = ~oe_pin;
        end else begin : g_high
            assign oe_asserted = oe_pin;
        end
    endgenerate

    // Driver machine: DRV_ON while the enable is asserted, DRV_OFF otherwise.
    always_comb begin
        unique case (oe_asserted)
            1'b1:    state = DRV_ON;
            default: state = DRV_OFF;
        endcase
    end
endmodule

// File: rtl/ubt_xcvr.sv
`timescale 1ns/1ps
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int WIDTH = 18
)
(
    inout  wire  [WIDTH-1:0] a_bus,
    inout  wire  [WIDTH-1:0] b_bus,
    input  logic             rst_n,
    input  logic             ab_oe,
    input  logic             ab_le,
    input  logic             ab_clk,
    input  logic             ba_oe_n,
    input  logic             ba_le,
    input  logic             ba_clk
);
    localparam logic [WIDTH-1:0] RELEASED = {WIDTH{1'bz}};

    logic [WIDTH-1:0] ab_out;
    logic [WIDTH-1:0] ab_held;
    logic [WIDTH-1:0] ba_out;
    logic [WIDTH-1:0] ba_held;
    drv_state_e       b_state;
    drv_state_e       a_state;

    ubt_path #(.WIDTH(WIDTH)) u_path_ab (
        .rst_n   (rst_n),
        .cap_clk (ab_clk),
        .le      (ab_le),
        .din     (a_bus),
        .dout    (ab_out),
        .held    (ab_held)
    );

    ubt_path #(.WIDTH(WIDTH)) u_path_ba (
        .rst_n   (rst_n),
        .cap_clk (ba_clk),
        .le      (ba_le),
        .din     (b_bus),
        .dout    (ba_out),
        .held    (ba_held)
    );

    ubt_oe_ctl #(.ACTIVE_LOW(1'b0)) u_oe_b (
        .oe_pin (ab_oe),
        .state  (b_state)
    );

    ubt_oe_ctl #(.ACTIVE_LOW(1'b1)) u_oe_a (
        .oe_pin (ba_oe_n),
        .state  (a_state)
    );

    assign b_bus = (b_state == DRV_ON) ? ab_out : RELEASED;
    assign a_bus = (a_state == DRV_ON) ? ba_out : RELEASED;

    AST_PASS_AB: assert property (@(posedge ab_clk) disable iff (!rst_n)
        (ab_oe && ab_le && ba_oe_n) |-> (b_bus == a_bus)); // R2
    AST_HOLD_AB: assert property (@(posedge ab_clk) disable iff (!rst_n)
        (ab_oe && !ab_le) |-> (b_bus == ab_held)); // R3
    AST_PASS_BA: assert property (@(posedge ba_clk) disable iff (!rst_n)
        (!ba_oe_n && ba_le && !ab_oe) |-> (a_bus == b_bus)); // R8
    AST_HOLD_BA: assert property (@(posedge ba_clk) disable iff (!rst_n)
        (!ba_oe_n && !ba_le) |-> (a_bus == ba_held)); // R8
    AST_B_RELEASE: assert property (@(posedge ab_clk) disable iff (!rst_n)
        (!ab_oe) |-> (b_state == DRV_OFF)); // R7
    AST_A_RELEASE: assert property (@(posedge ba_clk) disable iff (!rst_n)
        ba_oe_n |-> (a_state == DRV_OFF)); // R9
endmodule

// File: tb/ubt_xcvr_test.sv
`timescale 1ns/1ps
module ubt_xcvr_test;
    localparam int W          = 18;
    localparam int MAX_CYCLES = 200000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n   = 1'b0;
    logic         ab_oe   = 1'b0;
    logic         ab_le   = 1'b0;
    logic         ab_clk  = 1'b0;
    logic         ba_oe_n = 1'b1;
    logic         ba_le   = 1'b0;
    logic         ba_clk  = 1'b0;
    logic [W-1:0] a_drv   = '0;
    logic [W-1:0] b_drv   = '0;
    wire  [W-1:0] a_bus;
    wire  [W-1:0] b_bus;

    // The bench drives a port exactly when the design has released it.
    assign a_bus = ba_oe_n ? a_drv : {W{1'bz}};
    assign b_bus = ab_oe ? {W{1'bz}} : b_drv;

    ubt_xcvr #(.WIDTH(W)) uut (
        .a_bus   (a_bus),
        .b_bus   (b_bus),
        .rst_n   (rst_n),
        .ab_oe   (ab_oe),
        .ab_le   (ab_le),
        .ab_clk  (ab_clk),
        .ba_oe_n (ba_oe_n),
        .ba_le   (ba_le),
        .ba_clk  (ba_clk)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [W-1:0] m_qab = '0;
    logic [W-1:0] m_qba = '0;

    // Next stimulus
    logic [W-1:0] c_a = '0, c_b = '0;
    logic c_rn = 1'b0, c_aoe = 1'b0, c_ale = 1'b0, c_aclk = 1'b0;
    logic c_boe_n = 1'b1, c_ble = 1'b0, c_bclk = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Port values from the model; both design drivers are never on
    // while either path is transparent.
    task automatic eval_bus(input logic aoe, input logic ale,
                            input logic boe_n, input logic ble,
                            input logic [W-1:0] qab, input logic [W-1:0] qba,
                            output logic [W-1:0] av, output logic [W-1:0] bv);
        if (!aoe) begin
            bv = b_drv;
            av = boe_n ? a_drv : (ble ? bv : qba);
        end else begin
            av = boe_n ? a_drv : qba;
            bv = ale ? av : qab;
        end
    endtask

    // One clock: data first, controls half a nanosecond later, compare before the next edge.
    task automatic go(input string req);
        logic [W-1:0] pa, pb, ea, eb;
        @(negedge clk);
        a_drv = c_a;
        b_drv = c_b;
        #0.5;
        eval_bus(ab_oe, ab_le, ba_oe_n, ba_le, m_qab, m_qba, pa, pb);
        if (!c_rn) begin
            m_qab = '0;
            m_qba = '0;
        end else begin
            if ((ab_le && !c_ale) || (ab_clk && !c_aclk && !c_ale)) m_qab = pa;
            if ((ba_le && !c_ble) || (ba_clk && !c_bclk && !c_ble)) m_qba = pb;
        end
        rst_n   = c_rn;
        ab_oe   = c_aoe;
        ab_le   = c_ale;
        ab_clk  = c_aclk;
        ba_oe_n = c_boe_n;
        ba_le   = c_ble;
        ba_clk  = c_bclk;
        eval_bus(c_aoe, c_ale, c_boe_n, c_ble, m_qab, m_qba, ea, eb);
        #1;
        check(req, "port A", a_bus, ea);
        check(req, "port B", b_bus, eb);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset holds storage at zero even across clock edges
        c_a = 18'h3FFFF; c_b = 18'h15555;
        go("R1");
        c_aclk = 1'b1; c_bclk = 1'b1; go("R1");
        c_aclk = 1'b0; c_bclk = 1'b0; go("R1");
        c_rn = 1'b1; go("R1");
        c_aoe = 1'b1; go("R1");                 // B shows stored zero
        c_boe_n = 1'b0; go("R1 R10");           // both held: A shows zero too
        c_boe_n = 1'b1; go("R1");

        // R2: transparent A to B across patterns
        c_ale = 1'b1;
        c_a = 18'h00001; go("R2");
        c_a = 18'h3FFFF; go("R2");
        c_a = 18'h2AAAA; go("R2");
        c_a = 18'h15555; go("R2");
        for (int i = 0; i < W; i++) begin
            c_a = W'(1) << i;
            go("R2");
        end

        // R6: dropping the latch enable keeps the last transparent word
        c_a = 18'h01234; go("R2");
        c_ale = 1'b0; go("R6");
        c_a = 18'h03F00; go("R6");
        // R3: clock steady low
        c_a = 18'h00F0F; go("R3");
        // R5: rising clock does not update
        c_aclk = 1'b1; c_a = 18'h02222; go("R5");
        // R3: clock steady high
        c_a = 18'h03333; go("R3");
        // R4: falling clock captures current A
        c_a = 18'h00ABC; c_aclk = 1'b0; go("R4");
        c_a = 18'h00001; go("R3");

        // R6 with clock high when the enable falls
        c_aclk = 1'b1; go("R5");
        c_ale = 1'b1; c_a = 18'h03C3C; go("R2");
        c_ale = 1'b0; go("R6");
        c_a = 18'h00005; go("R6");
        c_aclk = 1'b0; go("R4");

        // R7: active-high enable releases port B when low
        c_aoe = 1'b0; c_b = 18'h02D2D; go("R7");
        c_b = 18'h00001; go("R7");
        c_aoe = 1'b1; go("R7");

        // R8: B to A modes
        c_aoe = 1'b0; go("R7");
        c_boe_n = 1'b0; c_ble = 1'b1;
        for (int i = 0; i < W; i++) begin
            c_b = (W'(1) << i) ^ 18'h2AAAA;
            go("R8");
        end
        c_b = 18'h01111; go("R8");
        c_ble = 1'b0; go("R8 R6");
        c_b = 18'h02222; go("R8");
        c_bclk = 1'b1; c_b = 18'h03333; go("R5");
        c_b = 18'h00777; c_bclk = 1'b0; go("R8");

        // R9: active-low enable releases port A when high
        c_boe_n = 1'b1; c_a = 18'h01357; go("R9");
        c_a = 18'h02468; go("R9");

        // R10: both enables on, both paths in hold
        c_aoe = 1'b1; go("R10");
        c_boe_n = 1'b0; go("R10");
        c_aclk = 1'b1; go("R10");
        c_aclk = 1'b0; go("R10");               // A-to-B loads the word B-to-A drives
        c_bclk = 1'b1; go("R10");
        c_bclk = 1'b0; go("R10");
        c_boe_n = 1'b1; go("R9");

        // Mixed random steps
        for (int k = 0; k < 400; k++) begin
            c_a = W'($urandom());
            c_b = W'($urandom());
            case ($urandom_range(0, 3))
                0: begin
                    if ($urandom_range(0, 1) == 1) c_aoe = ~c_aoe;
                    else c_boe_n = ~c_boe_n;
                    if (c_aoe && !c_boe_n && (c_ale || c_ble)) begin
                        c_aoe   = ab_oe;
                        c_boe_n = ba_oe_n;
                    end
                end
                1: begin
                    c_ale  = 1'($urandom());
                    c_aclk = 1'($urandom());
                    if (c_aoe && !c_boe_n) c_ale = 1'b0;
                end
                2: begin
                    c_ble  = 1'($urandom());
                    c_bclk = 1'($urandom());
                    if (c_aoe && !c_boe_n) c_ble = 1'b0;
                end
                default: ;
            endcase
            go("mixed R2 R3 R4 R5 R6 R7 R8 R9 R10");
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule